// File: doc/BRIEF.md
# Host Controller Interrupt and Command Register Unit

This unit keeps the command, interrupt status and interrupt mask state of a USB host controller and reduces it to one interrupt line. Software reaches it through a 32-bit synchronous register port with four word locations. The controller's engines report events through one-cycle strobes. Software raises command requests by writing ones into the command word. The engines acknowledge a request by pulsing the matching acknowledge bit.

Status bits are sticky. A strobe sets its bit, and software clears it by writing a one to it. The mask has no plain read/write location. One location sets mask bits and another clears them, and both read back the same mask. Bit 31 of the mask gates the whole interrupt output. A scheduling-overrun strobe sets status bit 0 and also advances a small wrapping counter, which software reads in the command word.

Top module: `hci_irq_unit`

## Requirements
- R1: While reset is held and after it is released, the command word, the status word, the mask and the overrun counter all read zero, and `irq_o` is low.
- R2: A write to word 0 (the command word) sets each command bit in [CMD_BITS-1:0] whose data bit is 1 and leaves bits written as 0 unchanged. A `cmd_done` bit clears its command bit. If a set and an acknowledge reach the same bit in one cycle, the bit stays set.
- R3: A 1 on `evt_in[i]` sets status bit i of word 1 for i in 0..30. Bit 6 is the root-hub change flag and bit 30 is the ownership-change flag. `ovr_evt` also sets status bit 0. Status bit 31 always reads 0.
- R4: A write to word 1 clears each status bit whose data bit is 1 and leaves bits written as 0 unchanged.
- R5: If an event and a software clear hit the same status bit in one cycle, the bit is set afterwards.
- R6: A write to word 2 sets each mask bit written as 1. A write to word 3 clears each mask bit written as 1. Bits written as 0 are unchanged at both locations. Reads of word 2 and of word 3 both return the mask.
- R7: `irq_o` is high exactly when mask bit 31 is 1 and some status bit i in 0..30 has mask bit i set. The output follows the registers with no added delay.
- R8: Each `ovr_evt` pulse adds one to a 2-bit overrun counter that wraps from 3 to 0. The counter is read in command-word bits [17:16]. Writes to the command word never change the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W | Word index (0 command, 1 status, 2 mask set, 3 mask clear) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| evt_in | input | 31 | Event strobes, one per status bit 0..30 |
| ovr_evt | input | 1 | Scheduling-overrun strobe |
| cmd_done | input | CMD_BITS | Per-bit acknowledge that clears command bits |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench drives a set and an acknowledge onto the same command bit in one cycle. A design that let the acknowledge win would silently drop a request. It also drives an event and a software clear onto the same status bit in one cycle. Getting that wrong loses an interrupt, and it shows up as a status read of 0 where 1 is expected.

The mask is programmed through both of its locations, with the master bit on and off. A design that modelled the mask as plain read/write, or that ignored the master gate, would raise `irq_o` in the wrong cycles. Five overrun pulses check the counter wrap. A command write with data in the counter field checks that software cannot disturb the counter.

// File: rtl/hci_irq_pkg.sv
package hci_irq_pkg;
   localparam int WORD_W     = 32;
   localparam int EVT_W      = 31;
   localparam int MASTER_BIT = 31;

   typedef enum logic [1:0] {
      RG_CMD = 2'd0,
      RG_STS = 2'd1,
      RG_ENA = 2'd2,
      RG_DIS = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic cmd;
      logic sts;
      logic ena;
      logic dis;
   } wr_dec_t;
endpackage

// File: rtl/hci_cmd_reg.sv
module hci_cmd_reg #(
   parameter int CMD_BITS = 4,
   parameter int OVR_W    = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                set_we,
   input  logic [CMD_BITS-1:0] set_data,
   input  logic [CMD_BITS-1:0] ack,
   input  logic                ovr_evt,
   output logic [CMD_BITS-1:0] cmd_q,
   output logic [OVR_W-1:0]    ovr_cnt
);
   logic [CMD_BITS-1:0] set_vec;

   assign set_vec = set_we ? set_data : '0;

   // requests: a set in the same cycle as an acknowledge survives
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmd_q <= '0;
      else        cmd_q <= (cmd_q & ~ack) | set_vec;
   end

   // wrapping overrun counter, read-only to software
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ovr_cnt <= '0;
      else if (ovr_evt) ovr_cnt <= ovr_cnt + OVR_W'(1);
   end
endmodule

// File: rtl/hci_status_bank.sv
module hci_status_bank #(
   parameter int NBITS = 31
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_we,
   input  logic [NBITS-1:0] clr_data,
   input  logic [NBITS-1:0] evt,
   output logic [NBITS-1:0] sts_q
);
   for (genvar i = 0; i < NBITS; i++) begin : g_bit
      logic clr_hit;
      assign clr_hit = clr_we & clr_data[i];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sts_q[i] <= 1'b0;
         else        sts_q[i] <= evt[i] | (sts_q[i] & ~clr_hit);
      end
   end
endmodule

// File: rtl/hci_mask_reg.sv
module hci_mask_reg #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ena_we,
   input  logic         dis_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] mask_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mask_q <= '0;
      else if (dis_we) mask_q <= mask_q & ~wdata;
      else if (ena_we) mask_q <= mask_q | wdata;
   end
endmodule

// File: rtl/hci_irq_unit.sv
module hci_irq_unit
   import hci_irq_pkg::*;
#(
   parameter int ADDR_W   = 2,
   parameter int CMD_BITS = 4,
   parameter int OVR_W    = 2,
   parameter int OVR_LSB  = 16,
   parameter int SO_BIT   = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [WORD_W-1:0]   bus_wdata,
   output logic [WORD_W-1:0]   bus_rdata,
   input  logic [EVT_W-1:0]    evt_in,
   input  logic                ovr_evt,
   input  logic [CMD_BITS-1:0] cmd_done,
   output logic                irq_o
);
   localparam int CNT_TOP = OVR_LSB + OVR_W;

   if (ADDR_W < 2)                begin : g_bad_addr initial $fatal(1, "ADDR_W below 2"); end
   if (CMD_BITS < 1 || CMD_BITS > OVR_LSB) begin : g_bad_cmd initial $fatal(1, "CMD_BITS overlaps counter"); end
   if (CNT_TOP > WORD_W)          begin : g_bad_cnt initial $fatal(1, "counter field exceeds word"); end
   if (SO_BIT < 0 || SO_BIT >= EVT_W) begin : g_bad_so initial $fatal(1, "SO_BIT out of range"); end

   logic                in_range;
   reg_sel_e            sel;
   wr_dec_t             wr_dec;
   logic [EVT_W-1:0]    evt_all;
   logic [CMD_BITS-1:0] cmd_q;
   logic [OVR_W-1:0]    ovr_cnt;
   logic [EVT_W-1:0]    sts_q;
   logic [WORD_W-1:0]   mask_q;
   logic [WORD_W-1:0]   cmd_word;

   if (ADDR_W > 2) begin : g_wide_addr
      assign in_range = ~|bus_addr[ADDR_W-1:2];
   end else begin : g_exact_addr
      assign in_range = 1'b1;
   end

   assign sel = reg_sel_e'(bus_addr[1:0]);

   always_comb begin
      wr_dec     = '0;
      wr_dec.cmd = bus_wr && in_range && sel == RG_CMD;
      wr_dec.sts = bus_wr && in_range && sel == RG_STS;
      wr_dec.ena = bus_wr && in_range && sel == RG_ENA;
      wr_dec.dis = bus_wr && in_range && sel == RG_DIS;
   end

   always_comb begin
      evt_all         = evt_in;
      evt_all[SO_BIT] = evt_in[SO_BIT] | ovr_evt;
   end

   hci_cmd_reg #(.CMD_BITS(CMD_BITS), .OVR_W(OVR_W)) u_cmd (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_we  (wr_dec.cmd),
      .set_data(bus_wdata[CMD_BITS-1:0]),
      .ack     (cmd_done),
      .ovr_evt (ovr_evt),
      .cmd_q   (cmd_q),
      .ovr_cnt (ovr_cnt)
   );

   hci_status_bank #(.NBITS(EVT_W)) u_sts (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_we  (wr_dec.sts),
      .clr_data(bus_wdata[EVT_W-1:0]),
      .evt     (evt_all),
      .sts_q   (sts_q)
   );

   hci_mask_reg #(.W(WORD_W)) u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .ena_we(wr_dec.ena),
      .dis_we(wr_dec.dis),
      .wdata (bus_wdata),
      .mask_q(mask_q)
   );

   always_comb begin
      cmd_word                   = '0;
      cmd_word[CMD_BITS-1:0]     = cmd_q;
      cmd_word[OVR_LSB +: OVR_W] = ovr_cnt;
   end

   always_comb begin
      bus_rdata = '0;
      if (in_range) begin
         unique case (sel)
            RG_CMD:         bus_rdata = cmd_word;
            RG_STS:         bus_rdata = {1'b0, sts_q};
            RG_ENA, RG_DIS: bus_rdata = mask_q;
         endcase
      end
   end

   assign irq_o = mask_q[MASTER_BIT] & (|(sts_q & mask_q[EVT_W-1:0]));
endmodule

// File: rtl/hci_irq_unit_chk.sv
module hci_irq_unit_chk #(
   parameter int ADDR_W   = 2,
   parameter int CMD_BITS = 4,
   parameter int OVR_W    = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_wr,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [31:0]         bus_wdata,
   input logic [30:0]         evt_in,
   input logic                ovr_evt,
   input logic [CMD_BITS-1:0] cmd_q,
   input logic [OVR_W-1:0]    ovr_cnt,
   input logic [30:0]         sts_q,
   input logic [31:0]         mask_q,
   input logic                irq_o
);
   logic wr_cmd, wr_sts, wr_ena, wr_dis;
   assign wr_cmd = bus_wr && bus_addr == ADDR_W'(0);
   assign wr_sts = bus_wr && bus_addr == ADDR_W'(1);
   assign wr_ena = bus_wr && bus_addr == ADDR_W'(2);
   assign wr_dis = bus_wr && bus_addr == ADDR_W'(3);

   // R2
   cmd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cmd |=> (cmd_q & $past(bus_wdata[CMD_BITS-1:0])) == $past(bus_wdata[CMD_BITS-1:0]));

   // R5
   evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_in != '0) |=> (sts_q & $past(evt_in)) == $past(evt_in));

   // R4
   sts_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sts && evt_in == '0 && !ovr_evt) |=> (sts_q & $past(bus_wdata[30:0])) == '0);

   // R6
   mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ena |=> (mask_q & $past(bus_wdata)) == $past(bus_wdata));

   // R6
   mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dis |=> (mask_q & $past(bus_wdata)) == '0);

   // R7
   master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_q[31] |-> !irq_o);

   // R7
   no_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((sts_q & mask_q[30:0]) == '0) |-> !irq_o);

   // R8
   ovr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_evt |=> ovr_cnt == $past(ovr_cnt) + OVR_W'(1));

   // R8
   ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ovr_evt |=> $stable(ovr_cnt));
endmodule

bind hci_irq_unit hci_irq_unit_chk #(
   .ADDR_W(ADDR_W), .CMD_BITS(CMD_BITS), .OVR_W(OVR_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .evt_in   (evt_in),
   .ovr_evt  (ovr_evt),
   .cmd_q    (cmd_q),
   .ovr_cnt  (ovr_cnt),
   .sts_q    (sts_q),
   .mask_q   (mask_q),
   .irq_o    (irq_o)
);

// File: tb/tb_hci_irq_unit.sv
`timescale 1ns/100ps
module tb_hci_irq_unit;
   localparam int ADDR_W = 2;
   localparam int CMD_BITS = 4;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                bus_wr = 1'b0;
   logic [ADDR_W-1:0]   bus_addr = '0;
   logic [31:0]         bus_wdata = '0;
   logic [31:0]         bus_rdata;
   logic [30:0]         evt_in = '0;
   logic                ovr_evt = 1'b0;
   logic [CMD_BITS-1:0] cmd_done = '0;
   logic                irq_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   // reference model state
   bit [3:0]  m_cmd;
   bit [30:0] m_sts;
   bit [31:0] m_mask;
   int        m_cnt;

   always #2 clk = ~clk;

   hci_irq_unit #(.ADDR_W(ADDR_W), .CMD_BITS(CMD_BITS)) dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in),
      .ovr_evt(ovr_evt), .cmd_done(cmd_done), .irq_o(irq_o));

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cmd = '0; m_sts = '0; m_mask = '0; m_cnt = 0;
      end else begin
         bit [30:0] ev;
         ev = evt_in;
         if (ovr_evt) ev[0] = 1'b1;
         if (bus_wr && bus_addr == 1) m_sts = m_sts & ~bus_wdata[30:0];
         m_sts = m_sts | ev;
         m_cmd = m_cmd & ~cmd_done;
         if (bus_wr && bus_addr == 0) m_cmd = m_cmd | bus_wdata[3:0];
         if (bus_wr && bus_addr == 2) m_mask = m_mask | bus_wdata;
         if (bus_wr && bus_addr == 3) m_mask = m_mask & ~bus_wdata;
         if (ovr_evt) m_cnt = (m_cnt + 1) % 4;
      end
   end

   function automatic bit [31:0] model_read(int a);
      case (a)
         0: return {14'd0, 2'(m_cnt), 12'd0, m_cmd};
         1: return {1'b0, m_sts};
         default: return m_mask;
      endcase
   endfunction

   function automatic bit model_irq();
      return m_mask[31] && ((m_sts & m_mask[30:0]) != 0);
   endfunction

   task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (!done) begin
         bit [31:0] e;
         string tag;
         e = model_read(int'(bus_addr));
         case (bus_addr)
            0: tag = "R2/R8 cmd word";
            1: tag = "R3 status word";
            default: tag = "R6 mask";
         endcase
         check(bus_rdata === e, tag, bus_rdata, e);
         check(irq_o === model_irq(), "R7 irq", {31'd0, irq_o}, {31'd0, model_irq()});
      end
   end

   task automatic drive(bit wr, int a, bit [31:0] d, bit [30:0] ev, bit ov, bit [3:0] ack);
      @(negedge clk); #1;
      bus_wr = wr; bus_addr = ADDR_W'(a); bus_wdata = d;
      evt_in = ev; ovr_evt = ov; cmd_done = ack;
   endtask

   task automatic wr_reg(int a, bit [31:0] d);
      drive(1'b1, a, d, '0, 1'b0, '0);
   endtask

   task automatic expect_rd(int a, bit [31:0] exp, string req);
      drive(1'b0, a, '0, '0, 1'b0, '0);
      @(negedge clk);
      check(bus_rdata === exp, req, bus_rdata, exp);
   endtask

   task automatic expect_irq(bit exp, string req);
      @(negedge clk);
      check(irq_o === exp, req, {31'd0, irq_o}, {31'd0, exp});
   endtask

   initial begin
      #400000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(bus_rdata === 32'd0 && irq_o === 1'b0, "R1 during reset", bus_rdata, 32'd0);
      #1 rst_n = 1'b1;
      // R1 after reset
      expect_rd(0, 32'd0, "R1 cmd");
      expect_rd(1, 32'd0, "R1 status");
      expect_rd(2, 32'd0, "R1 mask");
      expect_irq(1'b0, "R1 irq");

      // R2 command word
      wr_reg(0, 32'h5);
      expect_rd(0, 32'h5, "R2 set");
      wr_reg(0, 32'h2);
      expect_rd(0, 32'h7, "R2 zeros unchanged");
      drive(1'b0, 0, '0, '0, 1'b0, 4'h1);
      expect_rd(0, 32'h6, "R2 ack clears");
      drive(1'b1, 0, 32'h4, '0, 1'b0, 4'h4);
      expect_rd(0, 32'h6, "R2 set beats ack");

      // R3 / R4 / R5 status
      drive(1'b0, 1, '0, 31'h40, 1'b0, '0);
      expect_rd(1, 32'h40, "R3 hub change bit 6");
      drive(1'b0, 1, '0, 31'h4000_0000, 1'b0, '0);
      expect_rd(1, 32'h4000_0040, "R3 ownership bit 30");
      wr_reg(1, 32'h40);
      expect_rd(1, 32'h4000_0000, "R4 write one clears");
      wr_reg(1, 32'h0);
      expect_rd(1, 32'h4000_0000, "R4 write zero no effect");
      drive(1'b1, 1, 32'h20, 31'h20, 1'b0, '0);
      expect_rd(1, 32'h4000_0020, "R5 event beats clear");
      wr_reg(1, 32'hFFFF_FFFF);
      expect_rd(1, 32'h0, "R4 clear all, R3 bit 31 zero");

      // R6 / R7 mask and interrupt
      wr_reg(2, 32'h40);
      expect_rd(2, 32'h40, "R6 set via word 2");
      expect_rd(3, 32'h40, "R6 read via word 3");
      drive(1'b0, 1, '0, 31'h40, 1'b0, '0);
      drive(1'b0, 1, '0, '0, 1'b0, '0);
      expect_irq(1'b0, "R7 master off");
      wr_reg(2, 32'h8000_0000);
      drive(1'b0, 2, '0, '0, 1'b0, '0);
      expect_irq(1'b1, "R7 master on");
      wr_reg(3, 32'h40);
      expect_rd(2, 32'h8000_0000, "R6 clear via word 3");
      expect_irq(1'b0, "R7 source masked");
      wr_reg(2, 32'h20);
      expect_irq(1'b0, "R7 other bit enabled");
      wr_reg(1, 32'h7FFF_FFFF);

      // R8 overrun counter
      for (int i = 0; i < 5; i++) drive(1'b0, 0, '0, '0, 1'b1, '0);
      expect_rd(0, 32'h0001_0006, "R8 wrap after five");
      expect_rd(1, 32'h1, "R3 overrun sets bit 0");
      wr_reg(0, 32'h0003_0000);
      expect_rd(0, 32'h0001_0006, "R8 counter not writable");

      // mixed traffic, model compared every cycle
      for (int i = 0; i < 3000; i++) begin
         drive(($urandom % 4) == 0, int'($urandom % 4), $urandom,
               31'($urandom & $urandom & $urandom), ($urandom % 8) == 0,
               4'($urandom & $urandom));
      end
      drive(1'b0, 0, '0, '0, 1'b0, '0);
      @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule